// File: doc/BRIEF.md
# Buffered Reload Down-Counting Timer

This block is a single timer channel that sits behind a plain synchronous register port. Software writes a start value into a count-buffer register. A manual-update bit in the control register copies that buffered value into the active reload value. A later control write with start set and manual-update clear loads the down-counter and sets it running.

The counter steps down by one on every cycle where the tick-enable input is high. The tick source, usually a prescaled 12 MHz clock, is outside this block. The tick on which the count would go below zero is the expiry. On expiry the block raises a one-cycle interrupt pulse. If the auto-reload bit is set, the counter reloads and keeps running; if not, it stops at zero. A reload value of N therefore gives an expiry every N+1 ticks.

Software can read the remaining count at any time from the observation register. The register index is taken from byte-address bits [6:2]. Index 2 is control, index 15 is the count buffer and index 16 is the live count. Every other index up to 16 is a plain storage word.

Top module: `reload_timer`

## Requirements
- R1: After synchronous active-low reset, every register, the reload value, the count and the running state are zero, irq is low, and a read of any index returns zero.
- R2: A write to index 0, 1 or 3 to 15 (index = addr[6:2]) stores the full 32-bit word. A write to index 2 does the same. A later read of that index returns the stored word.
- R3: Writes to indices 17 to 31 change nothing, and reads of those indices return zero.
- R4: A control write (index 2) with bit 21 set copies the low CNT_W bits of the count buffer (index 15) into the reload value. It does not load or start the counter.
- R5: A control write with bit 21 clear and bit 20 set loads the count with the reload value on that clock edge and sets the channel running.
- R6: A running count changes only on cycles where tickEn is high.
- R7: A tick while the count is zero is an expiry. It drives irq high for exactly the following cycle, and irq is never high without an expiry.
- R8: On expiry with control bit 22 set, the count reloads and keeps running, so the period is reload+1 ticks. With bit 22 clear, the count stays at zero and no further expiries occur.
- R9: A control write with bit 20 clear stops the channel and holds its current count.
- R10: Writing the count buffer changes neither the reload value nor the count until a manual-update control write occurs.
- R11: A read of index 16 returns the live count, zero-extended. Writes to index 16 are ignored.
- R12: A control write in the same cycle as a tick takes priority, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (7) | Byte address; bits [6:2] select the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from addr |
| tickEn | input | 1 | Count-step enable |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
Read data is combinational, so it is sampled one time unit after addr changes on the falling edge. A register write or a control write takes effect on the next rising edge, so its effects are read back at the falling edge after that. A tick issued at a falling edge changes the count at the next rising edge, and irq is registered at that same edge. The bench therefore samples both the count and irq at the falling edge that ends the tick. It compares them with a period of reload+1 ticks, computed for every reload value in a sweep.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W    = 32;
  localparam int IDX_W     = 5;
  localparam int NUM_REGS  = 17;
  localparam int CTRL_IDX  = 2;
  localparam int BUF_IDX   = 15;
  localparam int OBS_IDX   = 16;
  localparam int START_BIT = 20;
  localparam int MANUAL_BIT = 21;
  localparam int AUTO_BIT  = 22;

  typedef struct packed {
    logic copyReload;   // buffer -> reload value
    logic loadCount;    // reload value -> count, begin run
    logic decrement;    // count - 1
    logic reloadCount;  // expiry with auto-reload
    logic expire;       // expiry pulse source
  } ctlStrobes_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              ctrlStart,
  input  logic              ctrlManual,
  input  logic              autoReload,
  input  logic              tickEn,
  input  logic              countZero,
  output ctlStrobes_t       strobes
);
  logic running;
  logic ctrlWr;
  logic active;

  always_comb begin
    ctrlWr              = wrEn && (wrIdx == IDX_W'(CTRL_IDX));
    active              = running && tickEn && !ctrlWr;
    strobes.copyReload  = ctrlWr && ctrlManual;
    strobes.loadCount   = ctrlWr && !ctrlManual && ctrlStart;
    strobes.expire      = active && countZero;
    strobes.decrement   = active && !countZero;
    strobes.reloadCount = active && countZero && autoReload;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (strobes.loadCount) begin
      running <= 1'b1;
    end else if (ctrlWr && !ctrlStart) begin
      running <= 1'b0;
    end else if (strobes.expire && !autoReload) begin
      running <= 1'b0;
    end
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wrData,
  input  ctlStrobes_t       strobes,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [CNT_W-1:0]  bufLow,
  output logic              countZero,
  output logic              irq
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    if (g == OBS_IDX) begin : gObs
      assign regs[g] = DATA_W'(countVal);
    end else begin : gStore
      always_ff @(posedge clk) begin
        if (!rstN) regs[g] <= '0;
        else if (wrEn && idx == IDX_W'(g)) regs[g] <= wrData;
      end
    end
  end

  assign ctrlWord  = regs[CTRL_IDX];
  assign bufLow    = regs[BUF_IDX][CNT_W-1:0];
  assign countZero = (countVal == '0);

  always_comb begin
    if (int'(idx) < NUM_REGS) rdData = regs[idx];
    else                      rdData = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
      countVal  <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= strobes.expire;
      if (strobes.copyReload) reloadVal <= bufLow;
      if (strobes.loadCount || strobes.reloadCount) countVal <= reloadVal;
      else if (strobes.decrement)                  countVal <= countVal - 1'b1;
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              tickEn,
  output logic              irq
);
  localparam int IDX_LSB = 2;

  logic [IDX_W-1:0]  wrIdx;
  logic [DATA_W-1:0] ctrlWord;
  logic [CNT_W-1:0]  countVal;
  logic [CNT_W-1:0]  reloadVal;
  logic [CNT_W-1:0]  bufLow;
  logic              countZero;
  ctlStrobes_t       strobes;

  assign wrIdx = addr[IDX_LSB +: IDX_W];

  timer_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .ctrlStart  (wrData[START_BIT]),
    .ctrlManual (wrData[MANUAL_BIT]),
    .autoReload (ctrlWord[AUTO_BIT]),
    .tickEn     (tickEn),
    .countZero  (countZero),
    .strobes    (strobes)
  );

  timer_datapath #(.CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .idx       (wrIdx),
    .wrData    (wrData),
    .strobes   (strobes),
    .rdData    (rdData),
    .ctrlWord  (ctrlWord),
    .countVal  (countVal),
    .reloadVal (reloadVal),
    .bufLow    (bufLow),
    .countZero (countZero),
    .irq       (irq)
  );
endmodule

// File: rtl/reload_timer_checker.sv
module reload_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [4:0]       wrIdx,
  input logic [31:0]      wrData,
  input logic             tickEn,
  input logic             irq,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] reloadVal,
  input logic [CNT_W-1:0] bufLow
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (wrIdx == 5'd2);

  p_irq_needs_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(tickEn));

  p_manual_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[21]) |=> (reloadVal == $past(bufLow)));

  p_start_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[21] && wrData[20]) |=> (countVal == $past(reloadVal)));

  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[20]) |=> $stable(countVal));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrEn) |=> $stable(countVal));
endmodule

bind reload_timer reload_timer_checker #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrIdx     (wrIdx),
  .wrData    (wrData),
  .tickEn    (tickEn),
  .irq       (irq),
  .countVal  (countVal),
  .reloadVal (reloadVal),
  .bufLow    (bufLow)
);

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
module tb_reload_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        tickEn = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] START = 32'h0010_0000;
  localparam logic [31:0] MAN   = 32'h0020_0000;
  localparam logic [31:0] AUTO  = 32'h0040_0000;

  always #2 clk = ~clk;

  reload_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tickEn(tickEn), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wrEn = 1'b1; addr = 7'(idx << 2); wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    addr = 7'(idx << 2);
    #1 d = rdData;
  endtask

  task automatic tick(output logic seen);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    seen = irq;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 32; i++) begin
      rd(i, v); check("R1 reset read", v, 0);
    end
    check("R1 irq low", {31'b0, irq}, 0);

    // R2: storage words
    for (int i = 0; i < 16; i++) begin
      if (i != 2) wr(i, 32'hA5000000 ^ (i * 32'h01010101));
    end
    wr(2, 32'h0000_00C3);
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      check("R2 readback", v, (i == 2) ? 32'h0000_00C3 : (32'hA5000000 ^ (i * 32'h01010101)));
    end

    // R3: out-of-range indices
    for (int i = 17; i < 32; i++) wr(i, 32'hFFFF_FFFF);
    for (int i = 17; i < 32; i++) begin
      rd(i, v); check("R3 high index reads zero", v, 0);
    end
    rd(1, v); check("R3 no alias onto index 1", v, 32'hA5000000 ^ 32'h01010101);

    // R11: writes to observation ignored
    wr(16, 32'h0000_FFFF);
    rd(16, v); check("R11 obs write ignored", v, 0);

    // R4 / R10 / R5
    wr(15, 7);
    wr(2, MAN);
    rd(16, v); check("R4 manual update does not start", v, 0);
    wr(15, 3);
    wr(2, START);
    rd(16, v); check("R10 buffer not used without update; R5 load", v, 7);
    seen = 0;
    tick(seen);
    rd(16, v); check("R6 decrement on tick", v, 6);
    wr(2, 0);

    // Sweep with auto-reload: R5 R6 R7 R8 R11
    for (int rel = 0; rel < 6; rel++) begin
      wr(15, rel);
      wr(2, MAN | AUTO);
      wr(2, START | AUTO);
      rd(16, v); check("R5 start loads reload", v, rel);
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k <= rel; k++) begin
          tick(seen);
          check("R7 irq on expiry only", {31'b0, seen}, (k == rel) ? 1 : 0);
          rd(16, v);
          check("R8 R11 live count", v, (k == rel) ? rel : rel - k - 1);
        end
        @(negedge clk);
        check("R7 one-cycle pulse", {31'b0, irq}, 0);
        @(negedge clk);
        rd(16, v);
        check("R6 idle holds count", v, rel);
      end
    end

    // Sweep without auto-reload: R8
    for (int rel = 0; rel < 6; rel++) begin
      wr(15, rel);
      wr(2, MAN);
      wr(2, START);
      for (int k = 0; k <= rel; k++) begin
        tick(seen);
        check("R7 single-shot irq", {31'b0, seen}, (k == rel) ? 1 : 0);
      end
      for (int k = 0; k < 3; k++) begin
        tick(seen);
        check("R8 no further irq", {31'b0, seen}, 0);
        rd(16, v); check("R8 stays zero", v, 0);
      end
    end

    // R9: stop holds count
    wr(15, 10);
    wr(2, MAN | AUTO);
    wr(2, START | AUTO);
    for (int k = 0; k < 4; k++) tick(seen);
    rd(16, v); check("R9 pre-stop count", v, 6);
    wr(2, AUTO);
    for (int k = 0; k < 3; k++) begin
      tick(seen);
      check("R9 no irq when stopped", {31'b0, seen}, 0);
    end
    rd(16, v); check("R9 count held", v, 6);

    // R12: control write beats coincident tick
    tickEn = 1'b1;
    wr(2, START | AUTO);
    tickEn = 1'b0;
    rd(16, v); check("R12 tick ignored during control write", v, 10);
    tick(seen);
    rd(16, v); check("R12 next tick counts", v, 9);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule